// File: doc/BRIEF.md
# Toggle-Bit Completion Poller for Parallel NOR Flash

This engine sits on the controller side of a parallel NOR flash. Software or a sequencer first sends a program or erase command sequence to the device, then pulses `start_i` with the address being worked on. The poller then reads that address twice in a row, over and over. Each read pair is compared. A device that is still busy flips its bit 6 on every read and keeps bit 5 low. A finished device returns array data, so bit 6 no longer changes between the two reads. A failed device keeps flipping bit 6 and raises bit 5. The data bus may carry several interleaved devices, one byte lane each, and all lanes are judged together.

The fault flag is taken only from the older read of a pair. A device can return to array mode between the two reads, and the newer read may then hold array data such as 0xFF, whose bit 5 is set. Reading the flag from the newer read would report that as a failure. When a fault is found, the engine writes the reset command 0xF0 (copied into every lane) to the device base address and then reports the failure. If neither outcome appears within `TIMEOUT_CYC` clock cycles of the start, the engine reports a timeout and writes nothing.

States and transitions:
- IDLE goes to RD_OLD on start.
- RD_OLD goes to RD_NEW when the read is accepted, or to FINISH if the timeout expires while the read is waiting.
- RD_NEW goes to EVAL when the read is accepted, or to FINISH on timeout.
- EVAL goes to FINISH with "done" if no lane toggled, to RST_WR if a lane toggled and a fault bit was set in the older read, to FINISH with "timeout" if the timer has expired, and otherwise back to RD_OLD.
- RST_WR goes to FINISH with "fail" when the write is accepted.
- FINISH goes to IDLE.

Top module: `toggle_poll_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `bus_req_o` are 0 and `result_o` is 2'b00 (none).
- R2: Every poll iteration makes two reads (`bus_we_o`=0) at the address latched at start. A transfer completes on a cycle where `bus_req_o` and `bus_rdy_i` are both 1. Until it completes, the request, address and write flag hold steady.
- R3: If a read pair has equal bit 6 (bit 8*k+6) in every lane k, the result is done (2'b01), and this pair is the last read pair.
- R4: While any lane's bit 6 differs within a pair and no fault is seen, polling continues with another pair.
- R5: The fault test uses bit 5 of the older read only. Bit 5 of the newer read has no effect on the result.
- R6: A fault is declared on the first toggling pair where any lane's older-read bit 5 (bit 8*k+5) is set. No further read pair is issued.
- R7: On a fault, exactly one write of 0xF0 in every byte lane goes to the base address latched at start, before the fail result (2'b10) appears. Done and timeout issue no write.
- R8: The timeout counter is cleared at start. If no outcome is reached within `TIMEOUT_CYC` cycles, the result is timeout (2'b11), reported within a few cycles of expiry.
- R9: `done_o` pulses high for exactly one cycle, in the same cycle that `result_o` takes its new value. `result_o` then holds until the next accepted start, which clears it to none.
- R10: `start_i` while busy is ignored. The poll address does not change and the sequence does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (taken only when idle) |
| poll_addr_i | input | ADDR_W | Address to poll |
| base_addr_i | input | ADDR_W | Device base address for the reset command |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Transfer address |
| bus_wdata_o | output | 8*LANES | Write data |
| bus_rdata_i | input | 8*LANES | Read data, valid when `bus_rdy_i` is 1 |
| bus_rdy_i | input | 1 | Transfer accepted / read data valid |
| busy_o | output | 1 | Engine is not idle |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 none, 01 done, 10 fail, 11 timeout |

## Verification
The hardest case to reach is a lane that leaves status mode exactly between the two reads of a pair. The older read must show bit 6 at 0 and the newer read must return 0xFF. That pair then toggles and carries a set bit 5, but only in the newer read.

The bench device model counts the reads it has answered and switches each lane to array data at a chosen read index. A directed case places that switch at an odd index with the toggle phase set so the older read is 0. Random cases vary the switch points, array bytes, fault lanes and bus wait states. The expected outcome and read count come from a bench replay of the pair rules.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int          LANE_W     = 8;
    localparam int          TOGGLE_BIT = 6;
    localparam int          FAULT_BIT  = 5;
    localparam logic [7:0]  RESET_CMD  = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_OLD,
        ST_RD_NEW,
        ST_EVAL,
        ST_RST_WR,
        ST_FINISH
    } poll_state_t;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_DONE    = 2'b01,
        RES_FAIL    = 2'b10,
        RES_TIMEOUT = 2'b11
    } poll_res_t;

endpackage

// File: rtl/toggle_pair_eval.sv
module toggle_pair_eval
    import flash_poll_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES*LANE_W-1:0] older_i,
    input  logic [LANES*LANE_W-1:0] newer_i,
    output logic                    toggling_o,
    output logic                    fault_o
);

    logic [LANES-1:0] lane_diff;
    logic [LANES-1:0] lane_fault;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // bit 6 compared across the pair; bit 5 only from the older read
        assign lane_diff[g]  = older_i[g*LANE_W+TOGGLE_BIT] ^ newer_i[g*LANE_W+TOGGLE_BIT];
        assign lane_fault[g] = older_i[g*LANE_W+FAULT_BIT];
    end

    assign toggling_o = |lane_diff;
    assign fault_o    = |lane_fault;

endmodule

// File: rtl/poll_timeout.sv
module poll_timeout #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);

    localparam int               CNT_W   = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != LIMIT_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIMIT_C);

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT_C);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/toggle_poll_engine.sv
module toggle_poll_engine
    import flash_poll_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int ADDR_W      = 24,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       poll_addr_i,
    input  logic [ADDR_W-1:0]       base_addr_i,
    output logic                    bus_req_o,
    output logic                    bus_we_o,
    output logic [ADDR_W-1:0]       bus_addr_o,
    output logic [LANES*LANE_W-1:0] bus_wdata_o,
    input  logic [LANES*LANE_W-1:0] bus_rdata_i,
    input  logic                    bus_rdy_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [1:0]              result_o
);

    localparam int DATA_W = LANES * LANE_W;

    poll_state_t        state_q, state_d;
    poll_res_t          res_q, res_d;
    logic               res_set;
    logic [ADDR_W-1:0]  addr_q, base_q;
    logic [DATA_W-1:0]  older_q, newer_q;
    logic               start_acc;
    logic               toggling, fault, expired;

    assign start_acc = (state_q == ST_IDLE) && start_i;

    toggle_pair_eval #(.LANES(LANES)) u_eval (
        .older_i    (older_q),
        .newer_i    (newer_q),
        .toggling_o (toggling),
        .fault_o    (fault)
    );

    poll_timeout #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_acc),
        .run_i     (busy_o),
        .expired_o (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            base_q  <= '0;
            older_q <= '0;
            newer_q <= '0;
            res_q   <= RES_NONE;
        end else begin
            if (start_acc) begin
                addr_q <= poll_addr_i;
                base_q <= base_addr_i;
                res_q  <= RES_NONE;
            end else if (res_set) begin
                res_q <= res_d;
            end
            if ((state_q == ST_RD_OLD) && bus_rdy_i) older_q <= bus_rdata_i;
            if ((state_q == ST_RD_NEW) && bus_rdy_i) newer_q <= bus_rdata_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        res_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_RD_OLD;
            end
            ST_RD_OLD: begin
                if (bus_rdy_i) begin
                    state_d = ST_RD_NEW;
                end else if (expired) begin
                    state_d = ST_FINISH;
                    res_d   = RES_TIMEOUT;
                    res_set = 1'b1;
                end
            end
            ST_RD_NEW: begin
                if (bus_rdy_i) begin
                    state_d = ST_EVAL;
                end else if (expired) begin
                    state_d = ST_FINISH;
                    res_d   = RES_TIMEOUT;
                    res_set = 1'b1;
                end
            end
            ST_EVAL: begin
                if (!toggling) begin
                    state_d = ST_FINISH;
                    res_d   = RES_DONE;
                    res_set = 1'b1;
                end else if (fault) begin
                    state_d = ST_RST_WR;
                end else if (expired) begin
                    state_d = ST_FINISH;
                    res_d   = RES_TIMEOUT;
                    res_set = 1'b1;
                end else begin
                    state_d = ST_RD_OLD;
                end
            end
            ST_RST_WR: begin
                if (bus_rdy_i) begin
                    state_d = ST_FINISH;
                    res_d   = RES_FAIL;
                    res_set = 1'b1;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = addr_q;
        bus_wdata_o = '0;
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_FINISH);
        unique case (state_q)
            ST_RD_OLD, ST_RD_NEW: begin
                bus_req_o = 1'b1;
            end
            ST_RST_WR: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = base_q;
                bus_wdata_o = {LANES{RESET_CMD}};
            end
            default: ;
        endcase
    end

    assign result_o = res_q;

    p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_rdy_i && !expired) |=>
            (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

    p_fail_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (result_o == RES_FAIL)) |-> $past(bus_req_o && bus_we_o && bus_rdy_i));

    p_no_write_else_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (result_o != RES_FAIL)) |-> !$past(bus_we_o));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |-> (result_o == RES_NONE));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(addr_q));

endmodule

// File: tb/tb_toggle_poll_engine.sv
`timescale 1ns/1ps
module tb_toggle_poll_engine;

    localparam int LANES   = 2;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 8 * LANES;
    localparam int TO_CYC  = 2000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] poll_addr_i = '0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic              bus_req_o, bus_we_o;
    logic [ADDR_W-1:0] bus_addr_o;
    logic [DATA_W-1:0] bus_wdata_o;
    logic [DATA_W-1:0] bus_rdata_i;
    logic              bus_rdy_i = 1'b0;
    logic              busy_o, done_o;
    logic [1:0]        result_o;

    always #10 clk = ~clk;

    toggle_poll_engine #(.LANES(LANES), .ADDR_W(ADDR_W), .TIMEOUT_CYC(TO_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .poll_addr_i(poll_addr_i), .base_addr_i(base_addr_i),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_rdy_i(bus_rdy_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    int checks = 0;
    int errors = 0;

    // device model: kind 0 completes at read nrd, 1 faults at read nrd, 2 never ends
    int         kind [LANES];
    int         nrd  [LANES];
    bit         tinit[LANES];
    logic [7:0] arr  [LANES];
    bit         rdy_always = 1'b0;

    int                rd_total = 0, wr_total = 0, mism = 0, rd_base = 0;
    logic [ADDR_W-1:0] exp_addr = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;

    function automatic logic [7:0] lane_byte(int l, int idx);
        logic [7:0] b;
        if (kind[l] == 0 && idx >= nrd[l]) return arr[l];
        b = 8'h00;
        b[6] = tinit[l] ^ idx[0];
        b[5] = (kind[l] == 1) && (idx >= nrd[l]);
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] dev_word(int idx);
        logic [DATA_W-1:0] w;
        for (int l = 0; l < LANES; l++) w[l*8 +: 8] = lane_byte(l, idx);
        return w;
    endfunction

    // replay of the pair rules: returns result code and read count
    function automatic void predict(output int res, output int nreads);
        logic [DATA_W-1:0] o, n;
        bit diff, flt;
        res = 3; nreads = -1;
        for (int p = 0; p < 1000; p++) begin
            o = dev_word(2*p); n = dev_word(2*p+1);
            diff = 0; flt = 0;
            for (int l = 0; l < LANES; l++) begin
                diff |= o[l*8+6] ^ n[l*8+6];
                flt  |= o[l*8+5];
            end
            if (!diff) begin res = 1; nreads = 2*p+2; return; end
            if (flt)   begin res = 2; nreads = 2*p+2; return; end
        end
    endfunction

    assign bus_rdata_i = dev_word(rd_total - rd_base);

    always @(negedge clk) bus_rdy_i <= rdy_always ? 1'b1 : (($urandom % 3) != 0);

    always @(posedge clk) begin
        if (bus_req_o && bus_rdy_i) begin
            if (bus_we_o) begin
                wr_total <= wr_total + 1;
                wr_addr  <= bus_addr_o;
                wr_data  <= bus_wdata_o;
            end else begin
                rd_total <= rd_total + 1;
                if (bus_addr_o != exp_addr) mism <= mism + 1;
            end
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(bit poke);
        int exp_res, exp_n, w0, m0, t0, cyc;
        logic [31:0] r;
        logic [ADDR_W-1:0] base;
        predict(exp_res, exp_n);
        @(negedge clk);
        rd_base = rd_total; w0 = wr_total; m0 = mism;
        r = $urandom; exp_addr = r[ADDR_W-1:0];
        r = $urandom; base = r[ADDR_W-1:0];
        poll_addr_i = exp_addr; base_addr_i = base; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; cyc = 1;
        if (poke) begin
            repeat (3) @(negedge clk);
            cyc += 3;
            poll_addr_i = ~exp_addr; start_i = 1'b1;   // R10 start while busy
            @(negedge clk); start_i = 1'b0; cyc++;
        end
        while (!done_o && cyc < 6000) begin @(negedge clk); cyc++; end
        if (!done_o) begin
            chk(0, "R9", "watchdog no done", 0, 1);
            return;
        end
        t0 = cyc;
        chk(result_o == exp_res[1:0], "R3/R5/R6/R8", "result", result_o, exp_res);
        if (exp_res != 3)
            chk((rd_total - rd_base) == exp_n, "R4/R6", "read count", rd_total - rd_base, exp_n);
        else
            chk(t0 >= TO_CYC && t0 <= TO_CYC + 4, "R8", "timeout cycles", t0, TO_CYC);
        chk(mism == m0, "R2/R10", "read address mismatches", mism - m0, 0);
        if (exp_res == 2) begin
            chk(wr_total - w0 == 1, "R7", "write count", wr_total - w0, 1);
            chk(wr_addr == base, "R7", "write addr", wr_addr, base);
            chk(wr_data == {LANES{8'hF0}}, "R7", "write data", wr_data, {LANES{8'hF0}});
        end else begin
            chk(wr_total == w0, "R7", "no write", wr_total - w0, 0);
        end
        @(negedge clk);
        chk(!done_o, "R9", "done one cycle", done_o, 0);
        chk(result_o == exp_res[1:0], "R9", "result held", result_o, exp_res);
    endtask

    task automatic set_lane(int l, int k, int n, bit ti, logic [7:0] a);
        kind[l] = k; nrd[l] = n; tinit[l] = ti; arr[l] = a;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int l = 0; l < LANES; l++) set_lane(l, 0, 1, 0, 8'h00);
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !bus_req_o && result_o == 2'b00, "R1", "reset state",
            {busy_o, done_o, bus_req_o, result_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !bus_req_o && result_o == 2'b00, "R1", "idle after reset",
            {busy_o, bus_req_o, result_o}, 0);

        // R3 plain completion, with an ignored start (R10)
        set_lane(0, 0, 20, 1, 8'h3C); set_lane(1, 0, 22, 0, 8'hA5);
        run_case(1);
        // R5 lane leaves status mode between older and newer read, array 0xFF
        set_lane(0, 0, 5, 0, 8'hFF); set_lane(1, 0, 2, 1, 8'h00);
        run_case(0);
        // R6 fault in one lane only
        set_lane(0, 0, 3, 0, 8'h12); set_lane(1, 1, 6, 1, 8'h00);
        run_case(0);
        // R6 both lanes fault
        set_lane(0, 1, 4, 1, 8'h00); set_lane(1, 1, 9, 0, 8'h00);
        run_case(0);
        // R4 long toggling with zero wait states
        rdy_always = 1'b1;
        set_lane(0, 0, 31, 0, 8'h40); set_lane(1, 0, 7, 0, 8'h40);
        run_case(0);
        rdy_always = 1'b0;
        // R8 timeout: device never completes
        set_lane(0, 2, 0, 0, 8'h00); set_lane(1, 2, 0, 1, 8'h00);
        run_case(0);

        // constrained random mix
        for (int i = 0; i < 25; i++) begin
            for (int l = 0; l < LANES; l++) begin
                logic [31:0] r;
                r = $urandom;
                set_lane(l, (r[3:0] < 4) ? 1 : 0, 1 + int'(r[9:4] % 40), r[10], r[23:16]);
            end
            run_case(0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule